// File: doc/BRIEF.md
# Decoded Johnson Divide-by-Eight Counter

This block is a four-stage twisted-ring counter that steps through eight states and shows the current state on eight one-hot decoded outputs. An active-low carry output is low for the upper half of the count and rises when the count wraps from 7 back to 0. That rise can serve as the rising count request of a following counter, so counters chain without extra logic.

Two count-request inputs drive the counter. One counts on its rising edge and the other counts on its falling edge, and each input gates the other. Both inputs are treated as synchronous signals, and their edges are found by comparing each input with its value at the previous system clock. An asynchronous clear overrides everything and returns the counter to state 0. The feedback into the first stage is shaped so that any unused four-bit pattern drains back into the valid ring after a few count events. A synchronous seed port loads any raw stage pattern, which makes those unused patterns reachable from outside.

Top module: `johnson_decoded_counter`

## Requirements
- R1: While `clr` is high, the outputs show state 0 (`dec_out` = 8'b0000_0001, `carry_n` = 1), and they do so without waiting for a clock edge.
- R2: A clock at which `adv_rise` is sampled high after having been low at the previous clock, while `adv_fall` is sampled low, advances the state by one.
- R3: A clock at which `adv_fall` is sampled low after having been high at the previous clock, while `adv_rise` is sampled high, advances the state by one.
- R4: No other input pattern changes the state. This covers a rising `adv_rise` while `adv_fall` is high, a falling `adv_fall` while `adv_rise` is low, and steady levels.
- R5: In a valid state k, `dec_out` has exactly bit k set. The count runs 0,1,...,7 and then wraps to 0.
- R6: `carry_n` is low in states 4 to 7 and high in states 0 to 3, so it rises on the wrap from 7 to 0.
- R7: With `seed_en` high at a clock, the stage pattern becomes `seed_code` (bit i = stage i). This takes priority over a count event at the same clock. State k has stages 0..k-1 set for k ≤ 4, and stages k-4..3 set for k > 4.
- R8: From any of the eight patterns outside the valid ring, the counter shows a valid one-hot state within 11 count events and then counts normally.
- R9: No count occurs at the first clock after `clr` falls. A level that is held across the clear is not taken as an edge.
- R10: A count becomes visible on the outputs at the clock edge that first samples the qualifying input level.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| clr | input | 1 | Asynchronous clear to state 0, active high |
| adv_rise | input | 1 | Count request, counts on a rising edge |
| adv_fall | input | 1 | Count request, counts on a falling edge |
| seed_en | input | 1 | Load `seed_code` into the stages |
| seed_code | input | STAGES | Raw stage pattern to load |
| dec_out | output | 2*STAGES | One-hot decoded state |
| carry_n | output | 1 | Low for the upper half of the count |

## Verification
A count event or a seed shows on the outputs at the single clock edge that samples it, which is one edge after the bench changes the inputs. The clear acts at once, with no clock at all. The bench changes inputs on the falling clock edge, updates its behavioural state index at that moment, and compares the outputs at the next falling edge, after exactly one rising edge has passed. The clear is checked a nanosecond after it rises. For an illegal seed, the bench counts the events it issues until the outputs become one-hot, checks that number against the bound, and then compares the normal sequence from the state it observed.

// File: rtl/jc_pkg.sv
package jc_pkg;
   // How the first-stage feedback handles patterns outside the ring
   typedef enum logic [0:0] {
      JC_FIX_GATED = 1'b0,  // gate the feedback term so bad codes drain in
      JC_FIX_FLUSH = 1'b1   // detect a bad code and jump straight to state 0
   } jc_fix_e;

   function automatic int unsigned jc_state_count(input int unsigned stages);
      return 2 * stages;
   endfunction

   function automatic int unsigned jc_fix_limit(input int unsigned stages);
      return 2 * stages + 3;
   endfunction
endpackage

// File: rtl/jc_edge_qual.sv
module jc_edge_qual (
   input  logic clk,
   input  logic clr,
   input  logic rise_in,
   input  logic fall_in,
   output logic step_o
);
   logic rise_q;
   logic fall_q;
   logic rise_hit;
   logic fall_hit;

   // The reset values block both edges at the first clock after release
   always_ff @(posedge clk or posedge clr) begin
      if (clr) begin
         rise_q <= 1'b1;
         fall_q <= 1'b0;
      end else begin
         rise_q <= rise_in;
         fall_q <= fall_in;
      end
   end

   always_comb begin
      rise_hit = rise_in & ~rise_q & ~fall_in;
      fall_hit = ~fall_in & fall_q & rise_in;
      step_o   = rise_hit | fall_hit;
   end

   // R9
   release_quiet_chk: assert property (@(posedge clk) disable iff (clr)
      $past(clr) |-> !step_o);
endmodule

// File: rtl/jc_ring.sv
module jc_ring #(
   parameter int unsigned     STAGES   = 4,
   parameter jc_pkg::jc_fix_e FIX_MODE = jc_pkg::JC_FIX_GATED
) (
   input  logic              clk,
   input  logic              clr,
   input  logic              step_i,
   input  logic              load_i,
   input  logic [STAGES-1:0] load_code_i,
   output logic [STAGES-1:0] q_o,
   output logic              legal_o
);
   localparam int unsigned FIX_LIMIT = jc_pkg::jc_fix_limit(STAGES);
   localparam int unsigned FIX_W     = $clog2(FIX_LIMIT + 2) + 1;

   if (STAGES < 3) begin : g_bad_stages
      $error("jc_ring needs at least three stages");
   end

   logic [STAGES-1:0] q;
   logic [STAGES-1:0] q_next;
   logic              head;
   logic              legal;

   // A ring code has at most one boundary between neighbouring stages
   always_comb begin
      int unsigned edges;
      edges = 0;
      for (int i = 0; i < STAGES - 1; i++) begin
         if (q[i] != q[i+1]) edges++;
      end
      legal = (edges <= 1);
   end

   if (FIX_MODE == jc_pkg::JC_FIX_GATED) begin : g_gated
      // The extra term only acts on codes outside the ring
      always_comb begin
         head   = ~q[STAGES-1] & ~(q[STAGES-2] & ~q[STAGES-3]);
         q_next = {q[STAGES-2:0], head};
      end
   end else begin : g_flush
      always_comb begin
         head   = ~q[STAGES-1];
         q_next = legal ? {q[STAGES-2:0], head} : '0;
      end
   end

   always_ff @(posedge clk or posedge clr) begin
      if (clr)         q <= '0;
      else if (load_i) q <= load_code_i;
      else if (step_i) q <= q_next;
   end

   assign q_o     = q;
   assign legal_o = legal;

   // Recovery watch: count events taken while outside the ring
   logic [FIX_W-1:0] fix_cnt;
   always_ff @(posedge clk or posedge clr) begin
      if (clr)                          fix_cnt <= '0;
      else if (legal || load_i)         fix_cnt <= '0;
      else if (step_i && !(&fix_cnt))   fix_cnt <= fix_cnt + 1'b1;
   end

   // R8
   recovery_bound_chk: assert property (@(posedge clk) disable iff (clr)
      fix_cnt <= FIX_LIMIT[FIX_W-1:0]);

   // R7
   seed_take_chk: assert property (@(posedge clk) disable iff (clr)
      load_i |=> q == $past(load_code_i));

   // R2
   shift_chk: assert property (@(posedge clk) disable iff (clr)
      (step_i && !load_i && legal) |=> q[STAGES-1:1] == $past(q[STAGES-2:0]));

   // R5
   stay_legal_chk: assert property (@(posedge clk) disable iff (clr)
      (step_i && !load_i && legal) |=> legal);
endmodule

// File: rtl/jc_decode.sv
module jc_decode #(
   parameter int unsigned STAGES = 4
) (
   input  logic [STAGES-1:0]   q_i,
   output logic [2*STAGES-1:0] dec_o,
   output logic                carry_n_o
);
   logic [STAGES-1:0] lower;
   logic [STAGES-1:0] upper;

   // Each state is named by one neighbouring pair of stages
   for (genvar k = 0; k < STAGES; k++) begin : g_pair
      if (k == 0) begin : g_ends
         assign lower[k] = ~q_i[0] & ~q_i[STAGES-1];
         assign upper[k] =  q_i[0] &  q_i[STAGES-1];
      end else begin : g_mid
         assign lower[k] =  q_i[k-1] & ~q_i[k];
         assign upper[k] = ~q_i[k-1] &  q_i[k];
      end
   end

   assign dec_o     = {upper, lower};
   assign carry_n_o = ~q_i[STAGES-1];
endmodule

// File: rtl/johnson_decoded_counter.sv
module johnson_decoded_counter #(
   parameter int unsigned     STAGES   = 4,
   parameter jc_pkg::jc_fix_e FIX_MODE = jc_pkg::JC_FIX_GATED
) (
   input  logic                clk,
   input  logic                clr,
   input  logic                adv_rise,
   input  logic                adv_fall,
   input  logic                seed_en,
   input  logic [STAGES-1:0]   seed_code,
   output logic [2*STAGES-1:0] dec_out,
   output logic                carry_n
);
   localparam int unsigned STATES = jc_pkg::jc_state_count(STAGES);

   logic              step;
   logic [STAGES-1:0] q;
   logic              legal;

   jc_edge_qual u_edge (
      .clk     (clk),
      .clr     (clr),
      .rise_in (adv_rise),
      .fall_in (adv_fall),
      .step_o  (step)
   );

   jc_ring #(.STAGES(STAGES), .FIX_MODE(FIX_MODE)) u_ring (
      .clk         (clk),
      .clr         (clr),
      .step_i      (step),
      .load_i      (seed_en),
      .load_code_i (seed_code),
      .q_o         (q),
      .legal_o     (legal)
   );

   jc_decode #(.STAGES(STAGES)) u_dec (
      .q_i       (q),
      .dec_o     (dec_out),
      .carry_n_o (carry_n)
   );

   // R1
   clear_state_chk: assert property (@(posedge clk)
      clr |-> (dec_out == STATES'(1)) && carry_n);

   // R5
   one_hot_chk: assert property (@(posedge clk) disable iff (clr)
      legal |-> $countones(dec_out) == 1);

   // R6
   carry_half_chk: assert property (@(posedge clk) disable iff (clr)
      legal |-> carry_n == (dec_out[STAGES-1:0] != '0));

   // R4
   hold_chk: assert property (@(posedge clk) disable iff (clr)
      (!seed_en && !step) |=> $stable(dec_out));
endmodule

// File: tb/johnson_decoded_counter_test.sv
`timescale 1ns/1ps
module johnson_decoded_counter_test;
   logic       clk = 1'b0;
   logic       clr = 1'b0;
   logic       adv_rise = 1'b0;
   logic       adv_fall = 1'b0;
   logic       seed_en = 1'b0;
   logic [3:0] seed_code = 4'h0;
   logic [7:0] dec_out;
   logic       carry_n;

   int n_checks = 0;
   int n_fails  = 0;
   bit finished = 0;

   // behavioural reference
   int idx = 0;
   bit mvalid = 1;
   bit pr = 1;
   bit pf = 0;

   always #2.5 clk = ~clk;

   johnson_decoded_counter uut (
      .clk(clk), .clr(clr), .adv_rise(adv_rise), .adv_fall(adv_fall),
      .seed_en(seed_en), .seed_code(seed_code),
      .dec_out(dec_out), .carry_n(carry_n)
   );

   function automatic logic [3:0] code_of(input int k);
      if (k <= 4) return 4'((1 << k) - 1);
      return 4'hF & ~4'((1 << (k - 4)) - 1);
   endfunction

   task automatic check(input string req, input int act, input int exp);
      n_checks++;
      if (act != exp) begin
         n_fails++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   task automatic compare(input string req);
      if (mvalid) begin
         check(req, int'(dec_out), 1 << idx);
         check({req, "/R6"}, int'(carry_n), (idx < 4) ? 1 : 0);
      end
   endtask

   // called at a falling edge; result compared one full cycle later
   task automatic step(input logic r, input logic f, input string req);
      bit ev;
      adv_rise = r;
      adv_fall = f;
      ev = (r && !pr && !f) || (!f && pf && r);
      pr = r;
      pf = f;
      if (ev && mvalid) idx = (idx + 1) % 8;
      @(posedge clk);
      @(negedge clk);
      compare(req);
   endtask

   task automatic clear_pulse();
      clr = 1'b1;
      #1;
      check("R1 dec", int'(dec_out), 1);
      check("R1 carry", int'(carry_n), 1);
      @(negedge clk);
      clr = 1'b0;
      idx = 0; mvalid = 1; pr = 1; pf = 0;
   endtask

   task automatic seed(input logic [3:0] code, input logic r, input logic f);
      int k;
      seed_en = 1'b1;
      seed_code = code;
      adv_rise = r;
      adv_fall = f;
      pr = r;
      pf = f;
      @(posedge clk);
      @(negedge clk);
      seed_en = 1'b0;
      mvalid = 0;
      for (int j = 0; j < 8; j++) if (code_of(j) == code) begin mvalid = 1; k = j; end
      if (mvalid) idx = k;
      compare("R7");
   endtask

   task automatic recover(input logic [3:0] code);
      int events;
      bit done;
      seed(code, 1'b0, 1'b0);
      check("R7 illegal seed not one-hot", ($countones(dec_out) == 1) ? 1 : 0, 0);
      events = 0;
      done = 0;
      for (int e = 0; e < 16 && !done; e++) begin
         step(1'b1, 1'b0, "R8");
         step(1'b0, 1'b0, "R8");
         events++;
         if ($countones(dec_out) == 1) begin
            done = 1;
            for (int j = 0; j < 8; j++) if (dec_out[j]) idx = j;
            mvalid = 1;
         end
      end
      check("R8 recovered", done ? 1 : 0, 1);
      check("R8 events within 11", (events <= 11) ? 1 : 0, 1);
      check("R8/R6 carry at recovery", int'(carry_n), (idx < 4) ? 1 : 0);
      for (int e = 0; e < 9; e++) begin
         step(1'b1, 1'b0, "R8 after");
         step(1'b0, 1'b0, "R8 after");
      end
   endtask

   initial begin
      #(200000 * 5);
      if (!finished) begin
         n_checks++;
         n_fails++;
         $display("FAIL watchdog: actual running expected done");
         $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
         $finish;
      end
   end

   initial begin
      #1;
      clr = 1'b1;
      repeat (2) @(negedge clk);
      check("R1 reset dec", int'(dec_out), 1);
      check("R1 reset carry", int'(carry_n), 1);
      clr = 1'b0;
      idx = 0; mvalid = 1; pr = 1; pf = 0;

      // R9: rise driven high in the first cycle after release is not an edge
      step(1'b1, 1'b0, "R9");
      step(1'b1, 1'b0, "R9");
      // R2 and R10: full wrap with rising edges, carry rises at the wrap
      for (int i = 0; i < 9; i++) begin
         step(1'b0, 1'b0, "R2");
         step(1'b1, 1'b0, "R10");
      end
      // R3: falling edges with adv_rise held high
      step(1'b1, 1'b1, "R3");
      for (int i = 0; i < 10; i++) begin
         step(1'b1, 1'b0, "R3");
         step(1'b1, 1'b1, "R3");
      end
      // R4: blocked rising edge, blocked falling edge, steady levels
      step(1'b0, 1'b1, "R4");
      step(1'b1, 1'b1, "R4 rise while fall high");
      step(1'b0, 1'b1, "R4");
      step(1'b0, 1'b0, "R4 fall while rise low");
      step(1'b0, 1'b0, "R4 steady");
      step(1'b1, 1'b0, "R5");
      step(1'b1, 1'b0, "R4 steady high");

      // R1: clear in mid-count with rise held high, R9: held level is no edge
      clear_pulse();
      step(1'b1, 1'b0, "R9 held");
      step(1'b1, 1'b0, "R9 held");
      step(1'b0, 1'b0, "R9");
      step(1'b1, 1'b0, "R9 real edge");
      // held-high adv_fall across clear, then a real fall
      step(1'b1, 1'b1, "R3");
      clear_pulse();
      step(1'b1, 1'b1, "R9");
      step(1'b1, 1'b0, "R3 after clear");

      // R7: every valid code, then seed against a same-cycle edge
      for (int k = 0; k < 8; k++) seed(code_of(k), 1'b0, 1'b0);
      step(1'b0, 1'b0, "R7");
      seed(code_of(6), 1'b1, 1'b0);
      step(1'b1, 1'b0, "R7 priority");
      step(1'b0, 1'b0, "R5");
      step(1'b1, 1'b0, "R5 wrap");

      // R8: every pattern outside the ring
      recover(4'b0010);
      recover(4'b0100);
      recover(4'b0101);
      recover(4'b0110);
      recover(4'b1001);
      recover(4'b1010);
      recover(4'b1011);
      recover(4'b1101);

      finished = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
      $finish;
   end
endmodule